// File: doc/BRIEF.md
# Bus Clock-Run Controller

This block takes part in the clock-stop handshake on a shared, active-low, open-drain clock-run line. A central clock source asks to stop the bus clock by letting the line float high. The block either lets the stop go ahead or refuses it by pulling the line low. It also produces the enables that gate the local core clock and a secondary interface clock. The line is modelled as a sampled input, `clkrun_in`, and a pull-low enable, `clkrun_drive_lo`. Outside the block the line level is the inverse of the OR of all pull-low enables. The clock-gate cell and the clock source sit outside and are driven by the enable outputs.

The controller has three named states. RUNNING (code 0) means the clock runs and the bus is operational. STOP_REQUESTED (code 1) means the central resource has asked for a stop. STOPPED (code 2) means the clock is off and the line is still watched for a restart. The transitions are:
- RUNNING→STOP_REQUESTED: a request, line seen high.
- STOP_REQUESTED→RUNNING: the refusal ends, or the wait is aborted.
- STOP_REQUESTED→STOPPED: the wait completes.
- STOPPED→RUNNING: restart, line seen low.

Within STOP_REQUESTED the block works in one of two modes: refusing, where it drives the line low, or accepting, where it counts down the stop delay. Within STOPPED it can also be waking, where it drives the line low to get the clock back.

Two configuration bits are loaded by a write strobe. The gating-enable bit resets to 0, and while it is 0 every stop request is refused. The secondary-domain disable bit is sticky: once set, only reset clears it.

Top module: `clkrun_ctrl`

## Requirements
- R1: After reset the state is RUNNING, `core_clk_en`=1, `aux_clk_en`=1, `clkrun_drive_lo`=0, and the line is never driven while in RUNNING.
- R2: `run_state` reports RUNNING=0, STOP_REQUESTED=1, STOPPED=2, and never shows 3.
- R3: In RUNNING, a high line sampled at a clock edge moves the block to STOP_REQUESTED at that edge.
- R4: If `local_busy`=1 or the gating bit is 0 at the entry edge, the block drives the line low for exactly the two cycles it spends in STOP_REQUESTED. It then returns to RUNNING, whatever the line does meanwhile.
- R5: If the block is idle with gating enabled, it stays four cycles in STOP_REQUESTED without driving and then enters STOPPED. `core_clk_en` is 0 exactly while in STOPPED.
- R6: During the accepting wait, a low line at any edge (including the edge that would complete the wait) returns the block to RUNNING.
- R7: If `local_busy` rises during the accepting wait, the block switches to refusing at the next edge. It then drives low for two cycles and returns to RUNNING.
- R8: In STOPPED, a low line at an edge returns the block to RUNNING with `core_clk_en`=1. A high line keeps it in STOPPED.
- R9: In STOPPED with the line high, `local_busy`=1 at an edge starts waking. The block drives the line low from the next cycle until it sees the line low, then returns to RUNNING.
- R10: The gating bit resets to 0 and is loaded from `cfg_gate_en` at an edge where `cfg_wr`=1.
- R11: A write with `cfg_aux_off`=1 forces `aux_clk_en` to 0 from the next cycle until reset. Later writes of 0 and all handshake states leave it at 0.
- R12: While the secondary domain is not disabled, `aux_clk_en` equals `core_clk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_gate_en | input | 1 | Gating-enable value to load |
| cfg_aux_off | input | 1 | Secondary-domain disable value (sets sticky bit) |
| clkrun_in | input | 1 | Sampled clock-run line level (0 = asserted) |
| local_busy | input | 1 | Local work pending / bus needed |
| clkrun_drive_lo | output | 1 | Pull-low enable for the clock-run line |
| core_clk_en | output | 1 | Core clock-gate enable |
| aux_clk_en | output | 1 | Secondary interface clock-gate enable |
| run_state | output | 2 | Handshake state code |

## Verification
Every output comes from registers, so each result appears one edge after the edge that samples its cause. A stop request gives STOP_REQUESTED, and the refusal drive where it applies, one edge later. A refusal returns to RUNNING three edges after the request. An accepted stop reaches STOPPED five edges after the request. A restart or wake takes effect one edge after the line is seen low. A configuration write takes effect on the edge that captures it. The bench changes inputs and samples outputs 1 ns after each rising edge and counts edges explicitly. This makes every check land on the exact cycle it predicts, including the abort and busy-rise offsets swept over every cycle of the accepting wait.

// File: rtl/clkrun_pkg.sv
package clkrun_pkg;
    typedef enum logic [1:0] {
        CR_RUNNING  = 2'd0,
        CR_STOP_REQ = 2'd1,
        CR_STOPPED  = 2'd2
    } cr_state_e;
endpackage

// File: rtl/clkrun_cfg.sv
module clkrun_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic gate_d,
    input  logic aux_off_d,
    output logic gate_en,
    output logic aux_off
);
    // gating bit is plain; the domain-disable bit only ever sets
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_en <= 1'b0;
            aux_off <= 1'b0;
        end else if (wr) begin
            gate_en <= gate_d;
            aux_off <= aux_off | aux_off_d;
        end
    end
endmodule

// File: rtl/clkrun_timer.sv
module clkrun_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/clkrun_fsm.sv
module clkrun_fsm
    import clkrun_pkg::*;
#(
    parameter int REFUSE_CYC = 2,
    parameter int STOP_DLY   = 4,
    parameter int CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             busy,
    input  logic             gate_en,
    input  logic [CNT_W-1:0] count,
    output logic             tmr_clr,
    output logic             tmr_inc,
    output cr_state_e        state,
    output logic             drive_lo,
    output logic             core_en
);
    localparam logic [CNT_W-1:0] REFUSE_LAST = CNT_W'(REFUSE_CYC - 1);
    localparam logic [CNT_W-1:0] STOP_LAST   = CNT_W'(STOP_DLY - 1);

    cr_state_e st_q, st_d;
    logic      refuse_q, refuse_d;
    logic      wake_q, wake_d;
    logic      blocker;

    assign blocker = busy | ~gate_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= CR_RUNNING;
            refuse_q <= 1'b0;
            wake_q   <= 1'b0;
        end else begin
            st_q     <= st_d;
            refuse_q <= refuse_d;
            wake_q   <= wake_d;
        end
    end

    // transitions
    always_comb begin
        st_d     = st_q;
        refuse_d = refuse_q;
        wake_d   = wake_q;
        tmr_clr  = 1'b0;
        tmr_inc  = 1'b0;
        unique case (st_q)
            CR_RUNNING: begin
                wake_d = 1'b0;
                if (line_in) begin
                    st_d     = CR_STOP_REQ;
                    refuse_d = blocker;
                    tmr_clr  = 1'b1;
                end
            end
            CR_STOP_REQ: begin
                if (refuse_q) begin
                    if (count == REFUSE_LAST) begin
                        st_d     = CR_RUNNING;
                        refuse_d = 1'b0;
                    end else begin
                        tmr_inc = 1'b1;
                    end
                end else if (!line_in) begin
                    st_d = CR_RUNNING;
                end else if (blocker) begin
                    refuse_d = 1'b1;
                    tmr_clr  = 1'b1;
                end else if (count == STOP_LAST) begin
                    st_d = CR_STOPPED;
                end else begin
                    tmr_inc = 1'b1;
                end
            end
            CR_STOPPED: begin
                if (!line_in) begin
                    st_d   = CR_RUNNING;
                    wake_d = 1'b0;
                end else if (busy) begin
                    wake_d = 1'b1;
                end
            end
            default: st_d = CR_RUNNING;
        endcase
    end

    // outputs
    always_comb begin
        state    = st_q;
        drive_lo = 1'b0;
        core_en  = 1'b1;
        unique case (st_q)
            CR_RUNNING:  ;
            CR_STOP_REQ: drive_lo = refuse_q;
            CR_STOPPED: begin
                drive_lo = wake_q;
                core_en  = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/clkrun_ctrl.sv
module clkrun_ctrl
    import clkrun_pkg::*;
#(
    parameter int REFUSE_CYC = 2,
    parameter int STOP_DLY   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_gate_en,
    input  logic       cfg_aux_off,
    input  logic       clkrun_in,
    input  logic       local_busy,
    output logic       clkrun_drive_lo,
    output logic       core_clk_en,
    output logic       aux_clk_en,
    output logic [1:0] run_state
);
    localparam int MAX_CYC = (STOP_DLY > REFUSE_CYC) ? STOP_DLY : REFUSE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             gate_en, aux_off;
    logic             tmr_clr, tmr_inc;
    logic [CNT_W-1:0] count;
    cr_state_e        state;

    clkrun_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .gate_d    (cfg_gate_en),
        .aux_off_d (cfg_aux_off),
        .gate_en   (gate_en),
        .aux_off   (aux_off)
    );

    clkrun_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .count (count)
    );

    clkrun_fsm #(
        .REFUSE_CYC (REFUSE_CYC),
        .STOP_DLY   (STOP_DLY),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (clkrun_in),
        .busy     (local_busy),
        .gate_en  (gate_en),
        .count    (count),
        .tmr_clr  (tmr_clr),
        .tmr_inc  (tmr_inc),
        .state    (state),
        .drive_lo (clkrun_drive_lo),
        .core_en  (core_clk_en)
    );

    assign run_state  = state;
    assign aux_clk_en = core_clk_en & ~aux_off;
endmodule

// File: rtl/clkrun_ctrl_chk.sv
module clkrun_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clkrun_in,
    input logic       clkrun_drive_lo,
    input logic       core_clk_en,
    input logic       aux_clk_en,
    input logic [1:0] run_state
);
    // R1
    no_drive_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'd0) |-> !clkrun_drive_lo);

    // R2
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_state != 2'd3);

    // R3
    stop_req_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'd0 && clkrun_in) |=> (run_state == 2'd1));

    // R4
    refuse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'd1 && clkrun_drive_lo && $past(clkrun_drive_lo)
         && $past(run_state) == 2'd1) |=> (run_state == 2'd0));

    // R5
    stop_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'd2 && $past(run_state) != 2'd2)
        |-> ($past(run_state) == 2'd1 && !core_clk_en));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'd2 && !clkrun_in) |=> (run_state == 2'd0 && core_clk_en));

    // R9
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'd2 && $past(run_state) == 2'd2 && $past(clkrun_drive_lo))
        |-> clkrun_drive_lo);

    // R11
    aux_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && !aux_clk_en) |=> !aux_clk_en);
endmodule

bind clkrun_ctrl clkrun_ctrl_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .clkrun_in       (clkrun_in),
    .clkrun_drive_lo (clkrun_drive_lo),
    .core_clk_en     (core_clk_en),
    .aux_clk_en      (aux_clk_en),
    .run_state       (run_state)
);

// File: tb/clkrun_ctrl_bench.sv
`timescale 1ns/1ps
module clkrun_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0, cfg_gate_en = 1'b0, cfg_aux_off = 1'b0;
    logic       local_busy = 1'b0;
    logic       host_pull = 1'b1;
    logic       clkrun_in;
    logic       clkrun_drive_lo, core_clk_en, aux_clk_en;
    logic [1:0] run_state;

    int total = 0, fails = 0, cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // open-drain line: low when anyone pulls
    assign clkrun_in = ~(host_pull | clkrun_drive_lo);

    clkrun_ctrl u_clkrun_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_wr          (cfg_wr),
        .cfg_gate_en     (cfg_gate_en),
        .cfg_aux_off     (cfg_aux_off),
        .clkrun_in       (clkrun_in),
        .local_busy      (local_busy),
        .clkrun_drive_lo (clkrun_drive_lo),
        .core_clk_en     (core_clk_en),
        .aux_clk_en      (aux_clk_en),
        .run_state       (run_state)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic g, input logic a);
        cfg_gate_en = g; cfg_aux_off = a; cfg_wr = 1'b1;
        step();
        cfg_wr = 1'b0;
    endtask

    // from RUNNING with idle and gating on: request and reach STOPPED
    task automatic go_stopped();
        host_pull = 1'b0;
        for (int i = 0; i < 5; i++) step();
        chk("R5 reach stopped", run_state, 2);
    endtask

    task automatic restart();
        host_pull = 1'b1;
        step();
        chk("R8 restart state", run_state, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            total++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        // R1 reset values
        chk("R1 state", run_state, 0);
        chk("R1 core_clk_en", core_clk_en, 1);
        chk("R1 aux_clk_en", aux_clk_en, 1);
        chk("R1 drive", clkrun_drive_lo, 0);

        // R10: gating bit resets to 0 -> idle request still refused
        host_pull = 1'b0;
        step();
        chk("R10 default refuse state", run_state, 1);
        chk("R10 default refuse drive", clkrun_drive_lo, 1);
        host_pull = 1'b1;
        step(); step();
        chk("R10 default refuse end", run_state, 0);

        // sweep busy x gate at request: R3, R4, R5, R8, R12
        for (int g = 0; g < 2; g++) begin
            for (int b = 0; b < 2; b++) begin
                bit blocked;
                blocked = (b == 1) || (g == 0);
                cfg(g[0], 1'b0);
                local_busy = b[0];
                host_pull = 1'b0;
                step();
                chk("R3 enter stop_req", run_state, 1);
                chk("R4 drive at entry", clkrun_drive_lo, int'(blocked));
                if (blocked) begin
                    host_pull = 1'b1;
                    step();
                    chk("R4 second drive cycle", clkrun_drive_lo, 1);
                    chk("R4 still stop_req", run_state, 1);
                    step();
                    chk("R4 back to running", run_state, 0);
                    chk("R4 drive released", clkrun_drive_lo, 0);
                end else begin
                    for (int i = 0; i < 3; i++) begin
                        step();
                        chk("R5 waiting state", run_state, 1);
                        chk("R5 no drive while waiting", clkrun_drive_lo, 0);
                        chk("R5 clock on while waiting", core_clk_en, 1);
                    end
                    step();
                    chk("R5 stopped", run_state, 2);
                    chk("R5 core gated", core_clk_en, 0);
                    chk("R12 aux follows core", aux_clk_en, 0);
                    step();
                    chk("R8 stays stopped on high line", run_state, 2);
                    restart();
                    chk("R8 core back on", core_clk_en, 1);
                    chk("R12 aux back on", aux_clk_en, 1);
                end
                local_busy = 1'b0;
            end
        end

        // R6: abort at each offset of the accepting wait
        for (int k = 0; k < 4; k++) begin
            host_pull = 1'b0;
            step();
            for (int i = 0; i < k; i++) step();
            chk("R6 still waiting", run_state, 1);
            host_pull = 1'b1;
            step();
            chk("R6 abort to running", run_state, 0);
            chk("R6 clock kept", core_clk_en, 1);
        end

        // R7: busy rises at each offset of the accepting wait
        for (int k = 0; k < 4; k++) begin
            host_pull = 1'b0;
            step();
            for (int i = 0; i < k; i++) step();
            local_busy = 1'b1;
            step();
            chk("R7 switched to refuse", run_state, 1);
            chk("R7 drive 1st", clkrun_drive_lo, 1);
            host_pull = 1'b1;
            step();
            chk("R7 drive 2nd", clkrun_drive_lo, 1);
            step();
            chk("R7 back to running", run_state, 0);
            chk("R7 drive released", clkrun_drive_lo, 0);
            local_busy = 1'b0;
        end

        // R9: wake from STOPPED by own drive
        go_stopped();
        local_busy = 1'b1;
        step();
        chk("R9 wake drive", clkrun_drive_lo, 1);
        chk("R9 still stopped", run_state, 2);
        host_pull = 1'b1;
        step();
        chk("R9 running after wake", run_state, 0);
        chk("R9 core on after wake", core_clk_en, 1);
        chk("R9 drive released", clkrun_drive_lo, 0);
        local_busy = 1'b0;

        // R10: clearing the gating bit blocks stopping again
        cfg(1'b0, 1'b0);
        host_pull = 1'b0;
        step();
        chk("R10 cleared bit refuses", clkrun_drive_lo, 1);
        host_pull = 1'b1;
        step(); step();
        chk("R10 cleared bit running", run_state, 0);

        // R11: sticky secondary-domain disable
        cfg(1'b1, 1'b1);
        chk("R11 aux off in running", aux_clk_en, 0);
        chk("R11 core unaffected", core_clk_en, 1);
        cfg(1'b1, 1'b0);
        chk("R11 write 0 keeps off", aux_clk_en, 0);
        go_stopped();
        restart();
        chk("R11 off after stop cycle", aux_clk_en, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule